// File: doc/BRIEF.md
# Width-Scalable Link Packet Serializer

This block turns packets into bit times on a point-to-point link whose lane count is 2, 4, 8, 16 or 32, chosen by a configuration input. Packets arrive as a stream of four-byte beats with a valid/ready handshake. Each beat carries a tag that marks the packet as control or data. Every beat becomes one 32-bit group on the link. The block spreads each group over 32/W bit times, where W is the lane count. It also drives a control line that gives the packet type and a framing strobe that marks the first bit time of every group.

The clock input is the bit-time clock: one output word per rising edge, so it runs at twice the forwarded link clock. When nothing is offered at a group boundary, the block sends an all-zero idle group with the control line high, so the receiver never loses group framing. A packet whose byte count is not a multiple of four is padded with zero bytes up to the next group.

Back-pressure rules: `in_ready` is high only in the bit time in which the next group is loaded. A beat is taken in a cycle where both `in_valid` and `in_ready` are high. While a beat waits, its fields must be held. Between beats of one packet, `in_valid` may drop. Every group the block loads while no beat is offered is an idle group, even in the middle of a packet.

Top module: `link_serializer`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `cad_o`, `ctl_o` and `frame_o` are 0.
- R2: In the k-th bit time of a group (counting from 0), `cad_o[W-1:0]` carries bits `[W*k +: W]` of the group. The group holds byte 0 in bits 7:0 and byte 3 in bits 31:24. Lanes W and above are 0.
- R3: A group occupies 32/W consecutive bit times. `frame_o` is high in the first bit time of each group and low in the others.
- R4: `ctl_o` is 1 for every group of a control packet (`in_ctl`=1) and 0 for every group of a data packet. It changes only in a bit time where `frame_o` is high.
- R5: When `in_valid` is low at a group boundary, the block sends an idle group: all 32 bits zero, `ctl_o` high.
- R6: `in_ready` is high exactly in the bit times in which a group starts in the following cycle, and never during reset. A taken beat appears starting in the next cycle.
- R7: On a beat with `in_last`=1, bytes whose index is above `in_nbytes_m1` are replaced by zero. On other beats all four bytes are sent.
- R8: Width codes are 0→2, 1→4, 2→8, 3→16, 4→32 lanes. Codes 5 to 7 are ignored and the current width is kept. The width after reset is 8.
- R9: `cfg_width` is sampled only at a group boundary outside a packet. A change made while a packet is in progress takes effect at the first group boundary after its last beat is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-time clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Beat offered |
| in_ready | output | 1 | Beat taken this cycle if valid |
| in_data | input | 32 | Four packet bytes, lowest byte first in bits 7:0 |
| in_last | input | 1 | Beat is the final one of its packet |
| in_nbytes_m1 | input | 2 | Valid bytes minus one on the final beat |
| in_ctl | input | 1 | Packet type: 1 control, 0 data |
| cfg_width | input | 3 | Lane-count code |
| cad_o | output | 32 | Link lanes for the current bit time |
| ctl_o | output | 1 | Control line |
| frame_o | output | 1 | First bit time of a group |

## Verification
Two events can fall in the same cycle: a group boundary that takes the final beat of a packet, and a width request that must then be honoured or deferred. The bench changes `cfg_width` during a packet, one beat into it. It expects the old width to last through the final group and the new width to start with the group after that. A reference model decides the expected width for every group. A reference deserializer rebuilds each group from the lanes and compares it with the padded bytes that were accepted, so lane placement is judged for every width across the change. Type changes between back-to-back control and data packets at 32 lanes are also provoked, because there the group boundary and the type change coincide in every cycle.

// File: rtl/sz_pkg.sv
package sz_pkg;
  localparam int unsigned GRP_BYTES = 4;
  localparam int unsigned GRP_BITS  = GRP_BYTES * 8;
  localparam int unsigned NB_W      = $clog2(GRP_BYTES);
  localparam int unsigned MAX_BEATS = GRP_BITS / 2;
  localparam int unsigned CNT_W     = $clog2(MAX_BEATS);

  typedef enum logic [2:0] {
    WD_2  = 3'd0,
    WD_4  = 3'd1,
    WD_8  = 3'd2,
    WD_16 = 3'd3,
    WD_32 = 3'd4
  } wd_e;

  function automatic logic code_ok(input logic [2:0] c);
    return c <= 3'd4;
  endfunction

  function automatic logic [5:0] lanes_of(input wd_e w);
    return 6'd2 << w;
  endfunction

  function automatic logic [CNT_W-1:0] last_beat_of(input wd_e w);
    return CNT_W'((MAX_BEATS >> w) - 1);
  endfunction

  function automatic logic [GRP_BITS-1:0] lane_mask(input wd_e w);
    return {GRP_BITS{1'b1}} >> (GRP_BITS - 32'(lanes_of(w)));
  endfunction
endpackage

// File: rtl/sz_group_src.sv
module sz_group_src
  import sz_pkg::*;
(
  input  logic                in_valid,
  input  logic [GRP_BITS-1:0] in_data,
  input  logic                in_last,
  input  logic [NB_W-1:0]     in_nbytes_m1,
  input  logic                in_ctl,
  output logic [GRP_BITS-1:0] grp_bits,
  output logic                grp_ctl
);
  logic [GRP_BYTES-1:0] keep;

  for (genvar b = 0; b < GRP_BYTES; b++) begin : g_byte
    assign keep[b] = !in_last || (NB_W'(b) <= in_nbytes_m1);
    assign grp_bits[b*8 +: 8] = (in_valid && keep[b]) ? in_data[b*8 +: 8] : 8'h00;
  end

  // idle groups are control-typed
  assign grp_ctl = in_valid ? in_ctl : 1'b1;
endmodule

// File: rtl/sz_width_ctl.sv
module sz_width_ctl
  import sz_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       grp_start,
  input  logic       take,
  input  logic       take_last,
  input  logic [2:0] cfg_width,
  output wd_e        wd_now,
  output wd_e        wd_q
);
  wd_e  wd_r;
  wd_e  wd_cand;
  logic pkt_r;

  always_comb begin
    wd_cand = wd_r;
    if (!pkt_r && code_ok(cfg_width)) wd_cand = wd_e'(cfg_width);
  end

  assign wd_now = grp_start ? wd_cand : wd_r;
  assign wd_q   = wd_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_r  <= WD_8;
      pkt_r <= 1'b0;
    end else if (grp_start) begin
      wd_r <= wd_cand;
      if (take) pkt_r <= !take_last;
    end
  end

  // R9
  wd_frozen_in_pkt_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_r |=> $stable(wd_r));
endmodule

// File: rtl/sz_lane_shift.sv
module sz_lane_shift
  import sz_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  wd_e                 wd,
  input  logic [GRP_BITS-1:0] grp_bits,
  input  logic                grp_ctl,
  output logic                grp_start,
  output logic [GRP_BITS-1:0] cad_o,
  output logic                ctl_o,
  output logic                frame_o
);
  logic [CNT_W-1:0]    left_r;
  logic [GRP_BITS-1:0] sh_r;

  assign grp_start = (left_r == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      left_r  <= '0;
      sh_r    <= '0;
      cad_o   <= '0;
      ctl_o   <= 1'b0;
      frame_o <= 1'b0;
    end else if (grp_start) begin
      cad_o   <= grp_bits & lane_mask(wd);
      sh_r    <= grp_bits >> lanes_of(wd);
      left_r  <= last_beat_of(wd);
      ctl_o   <= grp_ctl;
      frame_o <= 1'b1;
    end else begin
      cad_o   <= sh_r & lane_mask(wd);
      sh_r    <= sh_r >> lanes_of(wd);
      left_r  <= left_r - 1'b1;
      frame_o <= 1'b0;
    end
  end

  // R4
  ctl_group_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_o |-> $stable(ctl_o));
endmodule

// File: rtl/link_serializer.sv
module link_serializer
  import sz_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [GRP_BITS-1:0] in_data,
  input  logic                in_last,
  input  logic [NB_W-1:0]     in_nbytes_m1,
  input  logic                in_ctl,
  input  logic [2:0]          cfg_width,
  output logic [GRP_BITS-1:0] cad_o,
  output logic                ctl_o,
  output logic                frame_o
);
  logic                grp_start;
  logic [GRP_BITS-1:0] grp_bits;
  logic                grp_ctl;
  wd_e                 wd_now;
  wd_e                 wd_q;

  assign in_ready = grp_start && !rst;

  sz_group_src u_src (
    .in_valid     (in_valid),
    .in_data      (in_data),
    .in_last      (in_last),
    .in_nbytes_m1 (in_nbytes_m1),
    .in_ctl       (in_ctl),
    .grp_bits     (grp_bits),
    .grp_ctl      (grp_ctl)
  );

  sz_width_ctl u_wd (
    .clk       (clk),
    .rst       (rst),
    .grp_start (grp_start),
    .take      (in_valid && in_ready),
    .take_last (in_last),
    .cfg_width (cfg_width),
    .wd_now    (wd_now),
    .wd_q      (wd_q)
  );

  sz_lane_shift u_shift (
    .clk       (clk),
    .rst       (rst),
    .wd        (wd_now),
    .grp_bits  (grp_bits),
    .grp_ctl   (grp_ctl),
    .grp_start (grp_start),
    .cad_o     (cad_o),
    .ctl_o     (ctl_o),
    .frame_o   (frame_o)
  );

  // R2
  upper_lanes_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cad_o & ~lane_mask(wd_q)) == '0);

  // R3
  frame_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    frame_o && (wd_q != WD_32) |=> !frame_o);

  // R6
  ready_then_frame_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> frame_o);

  // R8
  width_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    code_ok(wd_q));
endmodule

// File: tb/link_serializer_tb_top.sv
module link_serializer_tb_top;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        v = 1'b0;
  logic [31:0] d = '0;
  logic        last = 1'b0;
  logic [1:0]  nb = 2'd3;
  logic        c = 1'b0;
  logic [2:0]  cw = 3'd2;
  logic        in_ready;
  logic [31:0] cad_o;
  logic        ctl_o;
  logic        frame_o;

  always #(PERIOD/2) clk = ~clk;

  link_serializer dut_i (
    .clk(clk), .rst(rst), .in_valid(v), .in_ready(in_ready), .in_data(d),
    .in_last(last), .in_nbytes_m1(nb), .in_ctl(c), .cfg_width(cw),
    .cad_o(cad_o), .ctl_o(ctl_o), .frame_o(frame_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string phase_tag = "R1";

  // reference model state
  int         m_wd = 2;
  int         m_lanes = 8;
  int         m_left = 0;
  bit         m_pkt = 0;
  bit         m_nop = 0;
  bit [31:0]  m_sh = '0;
  logic [31:0] exp_cad = '0;
  logic       exp_ctl = 1'b0;
  logic       exp_frame = 1'b0;

  // reference deserializer state
  bit [31:0]  gq[$];
  bit [31:0]  ds_acc = '0;
  int         ds_k = 0;
  bit         ds_on = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s [%s] actual=%h expected=%h t=%0t", req, phase_tag, act, exp, $time);
    end
  endtask

  function automatic bit [31:0] mask_of(input int l);
    return (l >= 32) ? 32'hffff_ffff : ((32'd1 << l) - 32'd1);
  endfunction

  function automatic bit [31:0] pad(input bit [31:0] x, input bit lst, input bit [1:0] n);
    bit [31:0] r = '0;
    for (int b = 0; b < 4; b++)
      if (!lst || b <= int'(n)) r[b*8 +: 8] = x[b*8 +: 8];
    return r;
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // one bit time: compare, advance model, wait for next negedge
  task automatic cyc(output bit acc);
    bit [31:0] g;
    bit [31:0] got;
    #1;
    chk(cad_o === exp_cad, m_nop ? "R5 idle lanes" : "R2 lanes", cad_o, exp_cad);
    chk(ctl_o === exp_ctl, m_nop ? "R5 idle ctl" : "R4 ctl", {31'b0, ctl_o}, {31'b0, exp_ctl});
    chk(frame_o === exp_frame, "R3 frame", {31'b0, frame_o}, {31'b0, exp_frame});
    chk(in_ready === (m_left == 0), "R6 ready", {31'b0, in_ready}, {31'b0, m_left == 0});
    // deserializer rebuilds the group from the lanes
    if (frame_o) begin ds_on = 1; ds_acc = '0; ds_k = 0; end
    if (ds_on) begin
      got = (cad_o & mask_of(m_lanes)) << (m_lanes * ds_k);
      ds_acc |= got;
      ds_k++;
      if (ds_k == 32 / m_lanes) begin
        ds_on = 0;
        if (gq.size() > 0) begin
          g = gq.pop_front();
          chk(ds_acc === g, "R2/R7 rebuilt group", ds_acc, g);
        end
      end
    end
    acc = (m_left == 0) && v;
    if (m_left == 0) begin
      if (!m_pkt && cw <= 3'd4) m_wd = int'(cw);
      m_lanes = 2 << m_wd;
      if (v) begin
        g = pad(d, last, nb); exp_ctl = c; m_pkt = !last; m_nop = 0;
      end else begin
        g = '0; exp_ctl = 1'b1; m_nop = 1;
      end
      gq.push_back(g);
      exp_cad = g & mask_of(m_lanes);
      m_sh = g >> m_lanes;
      m_left = 32 / m_lanes - 1;
      exp_frame = 1'b1;
    end else begin
      exp_cad = m_sh & mask_of(m_lanes);
      m_sh = m_sh >> m_lanes;
      m_left--;
      exp_frame = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    bit a;
    v = 1'b0;
    for (int i = 0; i < n; i++) cyc(a);
  endtask

  task automatic send(input bit typ, input int nbytes, input int seed,
                      input int chg_beat, input int chg_code, input int gap);
    int nbeat = (nbytes + 3) / 4;
    bit a;
    for (int i = 0; i < nbeat; i++) begin
      if (i == chg_beat) cw = 3'(chg_code);
      if (gap > 0 && i > 0) idle(gap);
      v = 1'b1; c = typ; last = (i == nbeat - 1);
      nb = last ? 2'((nbytes - 1) % 4) : 2'd3;
      for (int b = 0; b < 4; b++) d[b*8 +: 8] = 8'((seed * 17 + (i * 4 + b) * 29 + 5) & 255);
      a = 0;
      while (!a) cyc(a);
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog [%s] actual=%h expected=%h", phase_tag, 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: values held in reset
    chk(cad_o === '0 && ctl_o === 1'b0 && frame_o === 1'b0, "R1 reset outputs",
        {cad_o[29:0], ctl_o, frame_o}, 32'h0);
    chk(in_ready === 1'b0, "R6 no ready in reset", {31'b0, in_ready}, 32'h0);
    rst = 1'b0;
    phase_tag = "R1";
    idle(1);
    phase_tag = "R5";
    idle(6);
    for (int wc = 0; wc < 5; wc++) begin
      phase_tag = "R2";
      cw = 3'(wc);
      idle(2);
      send(1'b1, 4, wc, -1, 0, 0);
      send(1'b0, 8, wc + 10, -1, 0, 0);
      send(1'b0, 12, wc + 20, -1, 0, 0);
      idle(20);
    end
    phase_tag = "R7";
    cw = 3'd3;
    send(1'b0, 6, 31, -1, 0, 0);
    send(1'b1, 5, 32, -1, 0, 0);
    send(1'b0, 7, 33, -1, 0, 0);
    idle(20);
    phase_tag = "R9";
    cw = 3'd2;
    idle(4);
    send(1'b0, 16, 40, 1, 4, 0);
    send(1'b0, 8, 41, -1, 0, 0);
    idle(8);
    phase_tag = "R8";
    cw = 3'd6;
    idle(8);
    cw = 3'd7;
    send(1'b1, 8, 50, -1, 0, 0);
    idle(4);
    phase_tag = "R5";
    cw = 3'd1;
    idle(10);
    send(1'b0, 12, 60, -1, 0, 5);
    idle(20);
    phase_tag = "R4";
    cw = 3'd4;
    idle(4);
    send(1'b1, 4, 70, -1, 0, 0);
    send(1'b0, 4, 71, -1, 0, 0);
    send(1'b1, 8, 72, -1, 0, 0);
    send(1'b0, 12, 73, -1, 0, 0);
    idle(10);
    cw = 3'd0;
    send(1'b1, 4, 80, -1, 0, 0);
    idle(40);
    finish_run();
  end
endmodule